// File: doc/BRIEF.md
# Tile Attribute Decode and Pixel Colour Stage

This block sits in the pixel path of a tile-based video layer. For each screen pixel it receives one tile-map entry, a selector that says how that entry is packed, and the pixel's column and row inside a 16x16 tile. It decodes the character number and any colour, mirror and flip attributes. From these it forms the tile-set memory word address and the bit offset of the pixel inside that 16-bit word. The bits per pixel of the tile set are chosen at run time.

When the tile-set memory returns the addressed word, a fixed read latency later, the stage extracts the pixel. A zero pixel is replaced by the background colour. A non-zero pixel is offset by the foreground colour. The result is an 8-bit palette index. The attributes travel in a delay line next to the memory read, so every result stays paired with its own entry, and a new entry can be accepted on every cycle.

Top module: `tile_attr_stage`

## Requirements
- R1: With `map_mode`=0 (byte map), the character is `ent_word[7:0]`. Bits [31:8] are ignored, and the background colour, foreground colour, mirror and flip are all zero.
- R2: With `map_mode`=1, `ent_word[15:12]` is the background and `ent_word[11:8]` the foreground, each multiplied by 16. The character is `ent_word[7:0]`, and mirror and flip are zero.
- R3: With `map_mode`=2, `ent_word[15]` is flip, `ent_word[14]` is mirror and `ent_word[13:0]` is the character. Both colours are zero.
- R4: With `map_mode`=3, `ent_word[31:24]` is the background, `ent_word[23:16]` the foreground, `ent_word[15]` flip, `ent_word[14]` mirror and `ent_word[13:0]` the character.
- R5: The pixel index is char*256 + y'*16 + x'. x' = 15-x when mirror is set, else x. y' = 15-y when flip is set, else y.
- R6: `tile_depth` codes 0,1,2,4 and 3 select 1,2,4,16 and 8 bits per pixel respectively (code n means 2^n bits); codes above 4 act as 4. Words are 16 bits with pixel 0 in the least significant bits. `addr_word` is the pixel index divided by the pixels per word. `addr_bit` is the remainder times the bits per pixel.
- R7: When the extracted pixel (all of its bits) is zero, `col_idx` equals the background colour.
- R8: When the extracted pixel is non-zero, `col_idx` = (pixel bits [7:0] + foreground) modulo 256.
- R9: `addr_valid` rises one cycle after an entry is accepted. `pix_word` is sampled RD_LAT cycles after `addr_valid`. `col_valid` follows one cycle later. Entries may arrive on consecutive cycles, and their results keep their order and pairing.
- R10: A synchronous active-high reset clears `addr_valid`, `col_valid` and every entry in flight.
- R11: A cycle with `ent_valid` low produces no `addr_valid` and, later, no `col_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | 1 | Entry and pixel offsets are valid this cycle |
| map_mode | input | 2 | Map entry packing, 0..3 |
| ent_word | input | 32 | Tile-map entry |
| px_x | input | 4 | Pixel column inside the tile |
| px_y | input | 4 | Pixel row inside the tile |
| tile_depth | input | 3 | Tile-set bits per pixel code |
| addr_valid | output | 1 | Tile-set read request valid |
| addr_word | output | 22 | Tile-set word address |
| addr_bit | output | 4 | Bit offset of the pixel in the word |
| pix_word | input | 16 | Tile-set data, RD_LAT cycles after the request |
| col_valid | output | 1 | Palette index valid |
| col_idx | output | 8 | Final palette index |

## Verification
The embedded properties watch the valid handshake on every cycle. They check that an accepted entry always yields a request one cycle later and that an idle cycle never does. They check that each delayed request turns into exactly one colour result, that the byte map mode never carries colour attributes, and that every zero pixel comes out as the background colour. The bench scenarios must show the rest: the bit packing of each map mode, the mirror and flip address arithmetic, the word and bit split at each pixel depth, the modulo-256 foreground sum, and the pairing of attributes with pixels on a back-to-back stream.

// File: rtl/tile_stage_pkg.sv
package tile_stage_pkg;
  localparam int CHAR_W    = 14;          // widest character field
  localparam int TILE_LOG2 = 4;           // 16x16 pixel tiles
  localparam int WORD_LOG2 = 4;           // 16-bit tile-set words
  localparam int PIX_AW    = CHAR_W + 2 * TILE_LOG2;
  localparam int WORD_W    = 1 << WORD_LOG2;

  typedef enum logic [1:0] {
    MAP_8   = 2'd0,
    MAP_16A = 2'd1,
    MAP_16B = 2'd2,
    MAP_32  = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic [7:0]           bgc;
    logic [7:0]           fgc;
    logic [2:0]           depth;   // clamped to 0..4
    logic [WORD_LOG2-1:0] bit_ofs;
  } pix_ctx_t;
endpackage

// File: rtl/tile_entry_decode.sv
module tile_entry_decode
  import tile_stage_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [31:0]       word,
  output logic [CHAR_W-1:0] char_code,
  output logic              mir,
  output logic              flip,
  output logic [7:0]        bgc,
  output logic [7:0]        fgc
);
  map_mode_e m;
  assign m = map_mode_e'(mode);

  always_comb begin
    char_code = '0;
    mir       = 1'b0;
    flip      = 1'b0;
    bgc       = 8'h00;
    fgc       = 8'h00;
    unique case (m)
      MAP_8: begin
        char_code = CHAR_W'(word[7:0]);
      end
      MAP_16A: begin
        bgc       = {word[15:12], 4'h0};
        fgc       = {word[11:8], 4'h0};
        char_code = CHAR_W'(word[7:0]);
      end
      MAP_16B: begin
        flip      = word[15];
        mir       = word[14];
        char_code = word[CHAR_W-1:0];
      end
      MAP_32: begin
        bgc       = word[31:24];
        fgc       = word[23:16];
        flip      = word[15];
        mir       = word[14];
        char_code = word[CHAR_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_stage_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic [CHAR_W-1:0]    char_code,
  input  logic                 mir,
  input  logic                 flip,
  input  logic [TILE_LOG2-1:0] px_x,
  input  logic [TILE_LOG2-1:0] px_y,
  input  logic [2:0]           depth,
  input  logic [7:0]           bgc,
  input  logic [7:0]           fgc,
  output logic                 out_valid,
  output logic [PIX_AW-1:0]    word_addr,
  output pix_ctx_t             ctx
);
  localparam logic [TILE_LOG2-1:0] EDGE = {TILE_LOG2{1'b1}};

  logic [TILE_LOG2-1:0] xq, yq;
  logic [PIX_AW-1:0]    pix_idx;
  logic [2:0]           dc;
  logic [2:0]           sh;
  logic [WORD_LOG2-1:0] lo_mask;
  logic [WORD_LOG2-1:0] ofs;

  always_comb begin
    xq      = mir  ? (EDGE - px_x) : px_x;
    yq      = flip ? (EDGE - px_y) : px_y;
    pix_idx = {char_code, yq, xq};
    dc      = (depth > 3'd4) ? 3'd4 : depth;
    sh      = 3'(WORD_LOG2) - dc;
    lo_mask = {WORD_LOG2{1'b1}} >> dc;
    ofs     = WORD_LOG2'((pix_idx[WORD_LOG2-1:0] & lo_mask) << dc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      word_addr <= '0;
      ctx       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        word_addr   <= pix_idx >> sh;
        ctx.bgc     <= bgc;
        ctx.fgc     <= fgc;
        ctx.depth   <= dc;
        ctx.bit_ofs <= ofs;
      end
    end
  end

  // R9 / R11: request follows acceptance by one cycle, never otherwise
  p_req_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_no_req_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1: byte map entries carry no colour attributes
  p_byte_map_plain_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd0) |=> (ctx.bgc == 8'h00 && ctx.fgc == 8'h00));
endmodule

// File: rtl/tile_color_unit.sv
module tile_color_unit
  import tile_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  pix_ctx_t          ctx,
  input  logic [WORD_W-1:0] pix_word,
  output logic              out_valid,
  output logic [7:0]        col_idx
);
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] pixv;
  logic [7:0]        sum;
  logic [7:0]        col_d;

  always_comb begin
    shifted = pix_word >> ctx.bit_ofs;
    case (ctx.depth)
      3'd0:    mask = WORD_W'(16'h0001);
      3'd1:    mask = WORD_W'(16'h0003);
      3'd2:    mask = WORD_W'(16'h000F);
      3'd3:    mask = WORD_W'(16'h00FF);
      default: mask = {WORD_W{1'b1}};
    endcase
    pixv  = shifted & mask;
    sum   = pixv[7:0] + ctx.fgc;
    col_d = (pixv == '0) ? ctx.bgc : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      col_idx   <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) col_idx <= col_d;
    end
  end

  // R7: a zero pixel always yields the background colour
  p_zero_is_bg_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pixv == '0) |=> (col_idx == $past(ctx.bgc)));
endmodule

// File: rtl/tile_attr_stage.sv
module tile_attr_stage
  import tile_stage_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ent_valid,
  input  logic [1:0]  map_mode,
  input  logic [31:0] ent_word,
  input  logic [3:0]  px_x,
  input  logic [3:0]  px_y,
  input  logic [2:0]  tile_depth,
  output logic        addr_valid,
  output logic [21:0] addr_word,
  output logic [3:0]  addr_bit,
  input  logic [15:0] pix_word,
  output logic        col_valid,
  output logic [7:0]  col_idx
);
  localparam int LAT = (RD_LAT < 1) ? 1 : RD_LAT;

  logic [CHAR_W-1:0] dec_char;
  logic              dec_mir, dec_flip;
  logic [7:0]        dec_bgc, dec_fgc;
  logic              s1_valid;
  logic [PIX_AW-1:0] s1_addr;
  pix_ctx_t          s1_ctx;

  logic     dly_valid [LAT];
  pix_ctx_t dly_ctx   [LAT];

  tile_entry_decode u_dec (
    .mode      (map_mode),
    .word      (ent_word),
    .char_code (dec_char),
    .mir       (dec_mir),
    .flip      (dec_flip),
    .bgc       (dec_bgc),
    .fgc       (dec_fgc)
  );

  tile_addr_gen u_addr (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ent_valid),
    .in_mode   (map_mode),
    .char_code (dec_char),
    .mir       (dec_mir),
    .flip      (dec_flip),
    .px_x      (px_x),
    .px_y      (px_y),
    .depth     (tile_depth),
    .bgc       (dec_bgc),
    .fgc       (dec_fgc),
    .out_valid (s1_valid),
    .word_addr (s1_addr),
    .ctx       (s1_ctx)
  );

  assign addr_valid = s1_valid;
  assign addr_word  = s1_addr;
  assign addr_bit   = s1_ctx.bit_ofs;

  // attribute delay line matching the tile-set read latency
  genvar g;
  generate
    for (g = 0; g < LAT; g++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) begin
          dly_valid[g] <= 1'b0;
          dly_ctx[g]   <= '0;
        end else if (g == 0) begin
          dly_valid[g] <= s1_valid;
          dly_ctx[g]   <= s1_ctx;
        end else begin
          dly_valid[g] <= dly_valid[(g == 0) ? 0 : g - 1];
          dly_ctx[g]   <= dly_ctx[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  tile_color_unit u_col (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (dly_valid[LAT-1]),
    .ctx       (dly_ctx[LAT-1]),
    .pix_word  (pix_word),
    .out_valid (col_valid),
    .col_idx   (col_idx)
  );

  // R9: every delayed request produces exactly one colour result
  p_col_follows_r9: assert property (@(posedge clk) disable iff (rst)
    dly_valid[LAT-1] |=> col_valid);
  p_no_spurious_col_r9: assert property (@(posedge clk) disable iff (rst)
    !dly_valid[LAT-1] |=> !col_valid);
  // R10: reset leaves nothing in flight
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!addr_valid && !col_valid));
endmodule

// File: tb/tile_attr_stage_tb.sv
module tile_attr_stage_tb;
  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] ent;
    logic [3:0]  x;
    logic [3:0]  y;
    logic [2:0]  depth;
    logic [15:0] pix;
    logic [21:0] exp_addr;
    logic [3:0]  exp_bit;
    logic [7:0]  exp_col;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'hFFFF_FFA5, 4'd3,  4'd2,  3'd3, 16'h4700, 22'h005291, 4'd8,  8'h47}, // R1 R6
    '{2'd0, 32'h0000_0001, 4'd0,  4'd0,  3'd4, 16'h0000, 22'h000100, 4'd0,  8'h00}, // R1 R7
    '{2'd1, 32'h0000_3A42, 4'd5,  4'd7,  3'd2, 16'h0050, 22'h00109D, 4'd4,  8'hA5}, // R2 R8
    '{2'd1, 32'h0000_C801, 4'd15, 4'd15, 3'd1, 16'h3FFF, 22'h00003F, 4'd14, 8'hC0}, // R2 R7
    '{2'd1, 32'h0000_1F10, 4'd0,  4'd1,  3'd3, 16'h0020, 22'h000808, 4'd0,  8'h10}, // R2 R8 wrap
    '{2'd2, 32'h0000_4123, 4'd2,  4'd3,  3'd0, 16'h2000, 22'h001233, 4'd13, 8'h01}, // R3 R5 mirror
    '{2'd2, 32'h0000_BFFF, 4'd4,  4'd0,  3'd4, 16'h1234, 22'h3FFFF4, 4'd0,  8'h34}, // R3 R5 flip
    '{2'd2, 32'h0000_C000, 4'd1,  4'd14, 3'd3, 16'hAB00, 22'h00000F, 4'd0,  8'h00}, // R3 R5 both
    '{2'd3, 32'h1122_C005, 4'd0,  4'd0,  3'd2, 16'h7000, 22'h00017F, 4'd12, 8'h29}, // R4 R8
    '{2'd3, 32'hEE01_0007, 4'd9,  4'd6,  3'd1, 16'hFFF3, 22'h0000ED, 4'd2,  8'hEE}, // R4 R7
    '{2'd3, 32'h00FF_0002, 4'd1,  4'd0,  3'd4, 16'h0102, 22'h000201, 4'd0,  8'h01}  // R4 R6 R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_valid = 1'b0;
  logic [1:0]  map_mode = '0;
  logic [31:0] ent_word = '0;
  logic [3:0]  px_x = '0, px_y = '0;
  logic [2:0]  tile_depth = '0;
  logic [15:0] pix_word = '0;
  logic        addr_valid, col_valid;
  logic [21:0] addr_word;
  logic [3:0]  addr_bit;
  logic [7:0]  col_idx;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tile_attr_stage u_dut (
    .clk(clk), .rst(rst), .ent_valid(ent_valid), .map_mode(map_mode),
    .ent_word(ent_word), .px_x(px_x), .px_y(px_y), .tile_depth(tile_depth),
    .addr_valid(addr_valid), .addr_word(addr_word), .addr_bit(addr_bit),
    .pix_word(pix_word), .col_valid(col_valid), .col_idx(col_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    ent_valid  = vld;
    map_mode   = v.mode;
    ent_word   = v.ent;
    px_x       = v.x;
    px_y       = v.y;
    tile_depth = v.depth;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset addr_valid", addr_valid, 0);
    chk("R10 reset col_valid", col_valid, 0);
    rst = 1'b0;

    // table walk: one entry at a time
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i], 1'b1);
      @(negedge clk);
      ent_valid = 1'b0;
      pix_word  = VEC[i].pix;
      chk($sformatf("R9 vec%0d addr_valid", i), addr_valid, 1);
      chk($sformatf("R5 R6 vec%0d addr_word", i), addr_word, VEC[i].exp_addr);
      chk($sformatf("R6 vec%0d addr_bit", i), addr_bit, VEC[i].exp_bit);
      @(negedge clk);
      chk($sformatf("R9 vec%0d col early", i), col_valid, 0);
      @(negedge clk);
      chk($sformatf("R9 vec%0d col_valid", i), col_valid, 1);
      chk($sformatf("R7 R8 vec%0d col_idx", i), col_idx, VEC[i].exp_col);
    end

    // back-to-back stream: attributes must stay paired with pixels (R9)
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        chk($sformatf("R9 stream col_valid %0d", n - 3), col_valid, 1);
        chk($sformatf("R9 stream col_idx %0d", n - 3), col_idx, VEC[8 + n - 3].exp_col);
      end
      if (n < 3) drive(VEC[8 + n], 1'b1);
      else ent_valid = 1'b0;
      if (n >= 2 && n <= 4) pix_word = VEC[8 + n - 2].pix;
    end

    // idle cycles with changing inputs produce nothing (R11)
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      drive(VEC[n], 1'b0);
      pix_word = 16'hFFFF;
      chk("R11 idle addr_valid", addr_valid, 0);
      chk("R11 idle col_valid", col_valid, 0);
    end

    // reset in flight discards the entry (R10)
    @(negedge clk);
    drive(VEC[2], 1'b1);
    @(negedge clk);
    ent_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R10 flush addr_valid", addr_valid, 0);
    chk("R10 flush col_valid", col_valid, 0);
    rst = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R10 nothing after flush", col_valid, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule